// File: doc/BRIEF.md
# LCD Status Interrupt Line Generator

This block produces the status interrupt request of a tile-based video controller. On every dot clock it takes the current scanline, the dot position within that line, the video mode, the display-enable bit and the compare line. From these it keeps four registered interrupt sources: horizontal blank, vertical blank, OAM search and line compare. The four sources are ORed into one status line. Each 0-to-1 transition of that line gives a single-clock request on `irq_o`. The processor writes the status register through a one-cycle write strobe. The read value shows the stored enables, the live compare flag and the live mode.

The vertical-blank source does not simply follow mode 1. The block classifies each dot into one of five phases. PH_OFF applies while the display is disabled. PH_ACTIVE covers visible lines outside the quirk windows. PH_VB_HEAD covers dots 0..3 of line 144. PH_VB_BODY covers the rest of lines 144..153. PH_VB_TAIL covers dots 0..3 of line 0. The phases follow one another in the order ACTIVE → VB_HEAD → VB_BODY → VB_TAIL → ACTIVE as the counters advance. Any phase goes to OFF when the display is disabled, and OFF goes to ACTIVE or another phase when the display is enabled again. Each phase has its own rule for the vertical-blank source.

Top module: `lcd_stat_irq`

## Requirements
- R1: A status write stores written bits 6..3 as the enables. Bit 3 enables horizontal blank, bit 4 vertical blank, bit 5 OAM search and bit 6 line compare. The read value is {1, enables[6:3], line==compare, mode[1:0]}, so bit 7 always reads 1 and the written bits 7 and 2..0 are ignored.
- R2: The horizontal-blank source is high one cycle after mode is 0 with bit 3 enabled.
- R3: `irq_o` pulses for exactly one cycle when the ORed status line goes from 0 to 1. A source falling while another rises in the same cycle gives no pulse.
- R4: On line 144 the horizontal-blank source is forced low even when mode reads 0 and bit 3 is set.
- R5: On line 144, dots 0..3, the vertical-blank source follows bit 5 on dots 2 and 3. On dots 0 and 1 it is low when bit 5 is clear and holds its value when bit 5 is set.
- R6: On line 144 from dot 4 onward, and on lines 145..153, the vertical-blank source equals bit 4.
- R7: On line 0, dots 0..3, the vertical-blank source is high only when bit 4 is set and mode reads 1. From dot 4 of line 0, and on lines 1..143, it is low.
- R8: A write with bit 6, 4 or 3 clear clears the line-compare, vertical-blank or horizontal-blank source in the next cycle.
- R9: A write that sets bit 6 while the display is enabled and the scanline equals the compare line raises the line-compare source in the next cycle.
- R10: The OAM source is high one cycle after mode is 2 with bit 5 enabled.
- R11: Reset, or a cycle with the display disabled, clears every source and the stored previous line value, so no request is issued. The first rise after the display is enabled again does issue a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_en_i | input | 1 | Display enable |
| line_i | input | 8 | Current scanline, 0..153 |
| dot_i | input | 9 | Dot position in the line, 0..455 |
| mode_i | input | 2 | Current video mode (0 hblank, 1 vblank, 2 OAM, 3 transfer) |
| cmp_line_i | input | 8 | Compare scanline |
| stat_wr_i | input | 1 | Status register write strobe |
| stat_wdata_i | input | 8 | Status write data |
| stat_rd_o | output | 8 | Status register read value |
| irq_o | output | 1 | One-cycle status interrupt request |

## Verification
Mode sequences 2→0→0 and 0→2→3→2 separate a true edge detector from a level output. They also show that a hand-over from horizontal blank to OAM gives no pulse. Each of the dots 0..5 of line 144 is driven with bit 5 alone and then with bit 4 alone. This separates the short mode-2 spike from the continuous vertical-blank level. Line 0 is driven with the mode changing between 1 and 2 inside its first four dots, which shows that the tail window is gated by mode. Writes that clear and then set single enables, a jump from line 144 to 145 with mode held at 0, and display-off cycles show the immediate clears, the forced line-144 low and the cleared previous line value.

// File: rtl/lcd_stat_pkg.sv
package lcd_stat_pkg;

    parameter int LINE_W     = 8;
    parameter int DOT_W      = 9;
    parameter int VB_FIRST   = 144;
    parameter int VB_LAST    = 153;
    parameter int QUIRK_DOTS = 4;
    parameter int QUIRK_RISE = 2;

    typedef enum logic [2:0] {
        PH_OFF,
        PH_ACTIVE,
        PH_VB_HEAD,
        PH_VB_BODY,
        PH_VB_TAIL
    } phase_e;

    // enables as stored from status write bits 6..3
    typedef struct packed {
        logic cmp;
        logic oam;
        logic vbl;
        logic hbl;
    } stat_en_t;

    typedef struct packed {
        logic vbl;
        logic hbl;
        logic oam;
        logic cmp;
    } stat_src_t;

endpackage

// File: rtl/lcd_stat_phase.sv
module lcd_stat_phase
    import lcd_stat_pkg::*;
#(
    parameter int LW = LINE_W,
    parameter int DW = DOT_W
) (
    input  logic          disp_en_i,
    input  logic [LW-1:0] line_i,
    input  logic [DW-1:0] dot_i,
    output phase_e        phase_o
);
    localparam logic [LW-1:0] FIRST_L = LW'(VB_FIRST);
    localparam logic [LW-1:0] LAST_L  = LW'(VB_LAST);
    localparam logic [DW-1:0] QDOTS_L = DW'(QUIRK_DOTS);

    logic in_window;
    assign in_window = (dot_i < QDOTS_L);

    always_comb begin
        if (!disp_en_i)                                   phase_o = PH_OFF;
        else if ((line_i == FIRST_L) && in_window)        phase_o = PH_VB_HEAD;
        else if ((line_i >= FIRST_L) && (line_i <= LAST_L)) phase_o = PH_VB_BODY;
        else if ((line_i == '0) && in_window)             phase_o = PH_VB_TAIL;
        else                                              phase_o = PH_ACTIVE;
    end
endmodule

// File: rtl/lcd_stat_sources.sv
module lcd_stat_sources
    import lcd_stat_pkg::*;
#(
    parameter int LW = LINE_W,
    parameter int DW = DOT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_e        phase_i,
    input  logic [LW-1:0] line_i,
    input  logic [DW-1:0] dot_i,
    input  logic [1:0]    mode_i,
    input  logic [LW-1:0] cmp_line_i,
    input  logic          wr_i,
    input  logic [7:0]    wdata_i,
    output stat_en_t      en_o,
    output stat_src_t     src_o
);
    localparam logic [LW-1:0] FIRST_L = LW'(VB_FIRST);
    localparam logic [DW-1:0] RISE_L  = DW'(QUIRK_RISE);

    stat_en_t  en_q, en_eff;
    stat_src_t src_q, src_n;

    assign en_eff = wr_i ? stat_en_t'(wdata_i[6:3]) : en_q;

    always_comb begin
        src_n = '0;
        unique case (phase_i)
            PH_OFF: src_n = '0;
            PH_ACTIVE: src_n.vbl = 1'b0;
            PH_VB_HEAD: begin
                if (dot_i < RISE_L) src_n.vbl = en_eff.oam & src_q.vbl;
                else                src_n.vbl = en_eff.oam;
            end
            PH_VB_BODY: src_n.vbl = en_eff.vbl;
            PH_VB_TAIL: src_n.vbl = en_eff.vbl & (mode_i == 2'd1);
            default:    src_n = '0;
        endcase
        if (phase_i != PH_OFF) begin
            src_n.hbl = (line_i != FIRST_L) && (mode_i == 2'd0) && en_eff.hbl;
            src_n.oam = (mode_i == 2'd2) && en_eff.oam;
            src_n.cmp = en_eff.cmp && (line_i == cmp_line_i);
        end
        // status write clears disabled sources at once
        if (wr_i) begin
            if (!wdata_i[6]) src_n.cmp = 1'b0;
            if (!wdata_i[4]) src_n.vbl = 1'b0;
            if (!wdata_i[3]) src_n.hbl = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            src_q <= '0;
        end else begin
            en_q  <= en_eff;
            src_q <= src_n;
        end
    end

    assign en_o  = en_q;
    assign src_o = src_q;

    assert_hbl_line144_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (line_i == FIRST_L) |=> !src_q.hbl);
    assert_vbl_body_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == PH_VB_BODY && !wr_i) |=> (src_q.vbl == $past(en_q.vbl)));
    assert_wr_clear_vbl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !wdata_i[4]) |=> !src_q.vbl);
    assert_off_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == PH_OFF) |=> (src_q == '0));
endmodule

// File: rtl/lcd_stat_edge.sv
module lcd_stat_edge
    import lcd_stat_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      disp_en_i,
    input  stat_src_t src_i,
    output logic      irq_o
);
    logic line_now, line_prev_q;

    assign line_now = |src_i;
    assign irq_o    = line_now & ~line_prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n)          line_prev_q <= 1'b0;
        else if (!disp_en_i) line_prev_q <= 1'b0;
        else                 line_prev_q <= line_now;
    end

    assert_irq_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
    assert_irq_needs_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> line_now);
endmodule

// File: rtl/lcd_stat_irq.sv
module lcd_stat_irq
    import lcd_stat_pkg::*;
#(
    parameter int LW = LINE_W,
    parameter int DW = DOT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          disp_en_i,
    input  logic [LW-1:0] line_i,
    input  logic [DW-1:0] dot_i,
    input  logic [1:0]    mode_i,
    input  logic [LW-1:0] cmp_line_i,
    input  logic          stat_wr_i,
    input  logic [7:0]    stat_wdata_i,
    output logic [7:0]    stat_rd_o,
    output logic          irq_o
);
    phase_e    phase;
    stat_en_t  en;
    stat_src_t src;

    lcd_stat_phase #(.LW(LW), .DW(DW)) u_phase (
        .disp_en_i (disp_en_i),
        .line_i    (line_i),
        .dot_i     (dot_i),
        .phase_o   (phase)
    );

    lcd_stat_sources #(.LW(LW), .DW(DW)) u_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_i    (phase),
        .line_i     (line_i),
        .dot_i      (dot_i),
        .mode_i     (mode_i),
        .cmp_line_i (cmp_line_i),
        .wr_i       (stat_wr_i),
        .wdata_i    (stat_wdata_i),
        .en_o       (en),
        .src_o      (src)
    );

    lcd_stat_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .disp_en_i (disp_en_i),
        .src_i     (src),
        .irq_o     (irq_o)
    );

    assign stat_rd_o = {1'b1, en, (line_i == cmp_line_i), mode_i};

    assert_rd_enables_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr_i |=> (stat_rd_o[6:3] == $past(stat_wdata_i[6:3])));
endmodule

// File: tb/lcd_stat_irq_tb_top.sv
module lcd_stat_irq_tb_top;

    typedef struct {
        logic       irq;
        logic [7:0] stat;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       disp_en_i = 1'b0;
    logic [7:0] line_i = '0;
    logic [8:0] dot_i = '0;
    logic [1:0] mode_i = '0;
    logic [7:0] cmp_line_i = 8'd100;
    logic       stat_wr_i = 1'b0;
    logic [7:0] stat_wdata_i = '0;
    logic [7:0] stat_rd_o;
    logic       irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    exp_t q[$];

    // model state
    logic [3:0] m_en = '0;  // [3]=cmp(b6) [2]=oam(b5) [1]=vbl(b4) [0]=hbl(b3)
    logic m_vbl = 0, m_hbl = 0, m_oam = 0, m_cmp = 0;
    logic [7:0] cmp_v = 8'd100;

    always #5 clk = ~clk;

    lcd_stat_irq dut_i (
        .clk(clk), .rst_n(rst_n), .disp_en_i(disp_en_i), .line_i(line_i),
        .dot_i(dot_i), .mode_i(mode_i), .cmp_line_i(cmp_line_i),
        .stat_wr_i(stat_wr_i), .stat_wdata_i(stat_wdata_i),
        .stat_rd_o(stat_rd_o), .irq_o(irq_o)
    );

    task automatic step(input logic d, input logic [7:0] ln, input logic [8:0] dt,
                        input logic [1:0] md, input logic w, input logic [7:0] wd,
                        input string tag);
        logic [3:0] e;
        logic old_or, new_or, prev;
        exp_t x;
        @(negedge clk);
        disp_en_i = d; line_i = ln; dot_i = dt; mode_i = md;
        stat_wr_i = w; stat_wdata_i = wd; cmp_line_i = cmp_v;
        e = w ? wd[6:3] : m_en;
        old_or = m_vbl | m_hbl | m_oam | m_cmp;
        if (!d) begin
            m_vbl = 0; m_hbl = 0; m_oam = 0; m_cmp = 0; prev = 0;
        end else begin
            m_hbl = (ln != 8'd144) && (md == 2'd0) && e[0];
            m_oam = (md == 2'd2) && e[2];
            m_cmp = e[3] && (ln == cmp_v);
            if (ln == 8'd144 && dt < 9'd4)  m_vbl = (dt < 9'd2) ? (e[2] & m_vbl) : e[2];
            else if (ln >= 8'd144)          m_vbl = e[1];
            else if (ln == 8'd0 && dt < 9'd4) m_vbl = e[1] && (md == 2'd1);
            else                            m_vbl = 0;
            prev = old_or;
        end
        m_en = e;
        new_or = m_vbl | m_hbl | m_oam | m_cmp;
        x.irq  = new_or & ~prev;
        x.stat = {1'b1, m_en, (ln == cmp_v), md};
        x.tag  = tag;
        q.push_back(x);
    endtask

    // monitor / scoreboard
    always begin
        @(posedge clk);
        #2;
        if (q.size() > 0) begin
            exp_t x;
            x = q.pop_front();
            checks++;
            if (irq_o !== x.irq || stat_rd_o !== x.stat) begin
                failures++;
                $display("FAIL %s: irq=%0b stat=%02h expected irq=%0b stat=%02h",
                         x.tag, irq_o, stat_rd_o, x.irq, x.stat);
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if (irq_o !== 1'b0 || stat_rd_o !== 8'h80) begin
            failures++;
            $display("FAIL R11 reset: irq=%0b stat=%02h expected irq=0 stat=80", irq_o, stat_rd_o);
        end
        @(negedge clk); rst_n = 1'b1;

        // R1 / R2 / R3 / R10 mode patterns
        step(1, 10, 80, 2, 1, 8'h08, "R1 write hbl enable");
        step(1, 10, 300, 0, 0, 0, "R2 hblank rise");
        step(1, 10, 301, 0, 0, 0, "R3 level held no pulse");
        step(1, 10, 302, 0, 1, 8'h28, "R1 add oam enable");
        step(1, 11, 0, 2, 0, 0, "R3 hbl to oam handover");
        step(1, 11, 80, 3, 0, 0, "R10 oam drops in mode 3");
        step(1, 12, 0, 2, 0, 0, "R10 oam rise");
        step(1, 12, 90, 3, 0, 0, "R10 oam low");

        // R9 / R8 line compare
        cmp_v = 8'd20;
        step(1, 20, 100, 3, 1, 8'h40, "R9 compare on write");
        step(1, 20, 101, 3, 1, 8'h00, "R8 compare cleared");
        step(1, 20, 102, 3, 1, 8'h40, "R9 compare again");
        step(1, 20, 103, 3, 1, 8'h00, "R8 compare cleared again");
        cmp_v = 8'd100;

        // R8 hbl clear
        step(1, 30, 300, 0, 1, 8'h08, "R2 hbl on");
        step(1, 30, 301, 0, 1, 8'h00, "R8 hbl cleared");
        step(1, 30, 302, 0, 1, 8'h08, "R8 hbl back");

        // R4 forced low on line 144
        step(1, 143, 300, 0, 0, 0, "R4 setup");
        step(1, 144, 0, 0, 0, 0, "R4 forced low");
        step(1, 144, 1, 0, 0, 0, "R4 still low");
        step(1, 145, 0, 0, 0, 0, "R4 released on 145");

        // R5 spike with bit 5
        step(1, 143, 455, 3, 1, 8'h20, "R5 setup");
        step(1, 144, 0, 1, 0, 0, "R5 dot0 low");
        step(1, 144, 1, 1, 0, 0, "R5 dot1 low");
        step(1, 144, 2, 1, 0, 0, "R5 dot2 spike");
        step(1, 144, 3, 1, 0, 0, "R5 dot3 held");
        step(1, 144, 4, 1, 0, 0, "R6 dot4 bit4 clear");
        step(1, 144, 5, 1, 0, 0, "R6 dot5 low");
        step(1, 144, 6, 1, 1, 8'h30, "R6 bit4 set mid line");

        // R6 with bit 4 only
        step(1, 143, 455, 3, 1, 8'h10, "R6 setup");
        step(1, 144, 0, 1, 0, 0, "R5 bit5 clear dot0");
        step(1, 144, 2, 1, 0, 0, "R5 bit5 clear dot2");
        step(1, 144, 3, 1, 0, 0, "R5 bit5 clear dot3");
        step(1, 144, 4, 1, 0, 0, "R6 dot4 rise");
        step(1, 150, 0, 1, 0, 0, "R6 body held");
        step(1, 150, 1, 1, 1, 8'h00, "R8 vbl cleared");
        step(1, 150, 2, 1, 1, 8'h10, "R6 re-enable rise");

        // R7 tail window
        step(1, 153, 455, 1, 0, 0, "R7 setup");
        step(1, 0, 0, 1, 0, 0, "R7 tail mode1 held");
        step(1, 0, 1, 1, 0, 0, "R7 tail mode1 held");
        step(1, 0, 2, 2, 0, 0, "R7 tail mode2 cleared");
        step(1, 0, 3, 1, 0, 0, "R7 tail mode1 rise");
        step(1, 0, 4, 1, 0, 0, "R7 past window low");
        step(1, 0, 5, 1, 0, 0, "R7 stays low");

        // R11 display off
        step(1, 40, 300, 0, 1, 8'h08, "R11 setup");
        step(0, 40, 301, 0, 0, 0, "R11 display off");
        step(0, 40, 302, 0, 0, 0, "R11 display off held");
        step(1, 40, 303, 0, 0, 0, "R11 restart pulse");

        // R1 write data bits outside 6..3
        step(1, 41, 0, 2, 1, 8'h07, "R1 low bits ignored");
        step(1, 41, 1, 2, 1, 8'h7F, "R1 bit7 reads one");
        step(1, 41, 2, 2, 0, 0, "R10 oam held");

        @(negedge clk);
        stat_wr_i = 1'b0;
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule